// File: doc/BRIEF.md
# RTC Interrupt Flag Register

This block collects the interrupt sources of a real-time clock and turns them into one interrupt line. Three event sources feed it: a periodic source taken from a selectable tap of the clock's frequency divider, a one-cycle alarm-match pulse and a one-cycle pulse that marks the end of an update cycle. Each event sets its own sticky flag. The flag stays set until software reads the flag byte.

The flag byte is read-only and is cleared by reading it. Bit 7 is a summary flag. It is set when any flag is set while its enable input is also high. The interrupt output follows the summary flag as a level, so the line stays asserted until the byte is read or the matching enables are dropped.

All state is cleared by the resume-well reset, which is synchronous and active low. The alarm comparator and the update-tick generator are outside this block. Only their pulses come in.

Top module: `rtc_intflag`

## Requirements
- R1: While the resume-well reset is low, and after it is released, the flag byte reads 0x00 and the interrupt output is low until an event occurs.
- R2: An alarm pulse sets bit 5 of the flag byte in the following cycle. The bit then stays set until a read clears it.
- R3: An update-ended pulse sets bit 4 of the flag byte in the following cycle. The bit then stays set until a read clears it.
- R4: A rate select value k between 1 and NTAPS picks divider tap k-1. Bit 6 is set in the cycle after that tap changes from 0 to 1. A tap that stays at 1 does not set the bit again.
- R5: A rate select value of 0, or any value above NTAPS, picks no tap, and bit 6 never sets.
- R6: Bit 7 equals (bit 6 AND periodic enable) OR (bit 5 AND alarm enable) OR (bit 4 AND update enable). Bits 3 to 0 always read 0.
- R7: The interrupt output always equals bit 7 of the flag byte.
- R8: A read strobe clears bits 6 to 4 in the next cycle.
- R9: An event that arrives in the same cycle as a read strobe leaves its flag set after that read.
- R10: Changing the enable inputs changes only bit 7 and the interrupt output. Bits 6 to 4 are never changed by the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Resume-well reset, synchronous, active low |
| div_taps | input | NTAPS | Divider tap levels |
| rate_sel | input | SEL_W | Tap select for the periodic source, 0 = none |
| alarm_evt | input | 1 | Alarm match pulse |
| update_evt | input | 1 | Update-ended pulse |
| pie | input | 1 | Periodic interrupt enable |
| aie | input | 1 | Alarm interrupt enable |
| uie | input | 1 | Update-ended interrupt enable |
| rd_stb | input | 1 | Read strobe of the flag byte (clears on read) |
| flag_byte | output | 8 | Flag byte: bit 7 summary, 6 periodic, 5 alarm, 4 update |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest case to reach is an event that lands in the same cycle as a clearing read. The periodic case is harder still, because its event is a 0-to-1 change on a tap and not a pulse. The bench drives the tap lines itself, so it can place a rising edge exactly on a read cycle, and it does the same with alarm and update pulses. A long random phase follows. It changes taps, rate select, enables and read strobes every cycle against a behavioural model, so that coincident events also occur with the select field moving under them.

// File: rtl/rtcf_pkg.sv
// Shared definitions for the RTC interrupt flag register.
// Assumes the bit positions of the flag byte are fixed by software.
package rtcf_pkg;
    localparam int NUM_SRC  = 3;
    localparam int BIT_IRQ  = 7;
    localparam int BIT_PER  = 6;
    localparam int BIT_ALM  = 5;
    localparam int BIT_UPD  = 4;

    // Source order inside vectors: [2]=periodic, [1]=alarm, [0]=update
    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } rtcf_src_t;
endpackage

// File: rtl/rtcf_tap_edge.sv
// Picks one divider tap by the rate select and reports its rising edge.
// Assumes the tap lines are synchronous to clk. Select 0, or a value above
// NTAPS, selects nothing. Every tap has its own history, so changing the
// select does not make a false edge.
module rtcf_tap_edge #(
    parameter int NTAPS = 15,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTAPS-1:0] taps,
    input  logic [SEL_W-1:0] sel,
    output logic             rise
);
    logic [NTAPS-1:0] prev_q;
    logic [NTAPS-1:0] sel_hit;
    logic [NTAPS-1:0] rise_vec;

    // Remember last tap levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= taps;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NTAPS; gi++) begin : g_tap
            // Decode select value gi+1 onto this tap
            assign sel_hit[gi]  = (sel == SEL_W'(gi + 1));
            assign rise_vec[gi] = taps[gi] & ~prev_q[gi];
        end
    endgenerate

    // Edge of the selected tap only
    always_comb rise = |(rise_vec & sel_hit);
endmodule

// File: rtl/rtcf_flag_cell.sv
// One sticky event flag. A set wins over a clear in the same cycle,
// so an event that arrives with a clearing read is not lost.
module rtcf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Hold, set on event, drop on read unless an event arrives too
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end
endmodule

// File: rtl/rtcf_irq_merge.sv
// Forms the summary request from the flags and their enables.
// Purely combinational. Assumes the flag and enable vectors line up bit by bit.
module rtcf_irq_merge #(
    parameter int N = 3
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         req
);
    // OR of each flag gated by its enable
    always_comb req = |(flags & enables);
endmodule

// File: rtl/rtc_intflag.sv
// RTC interrupt flag register: latches periodic, alarm and update-ended
// events into sticky flags and presents them as a clear-on-read byte with a
// summary bit that drives the interrupt level. Assumes rd_stb is high for one
// cycle per read, and that the byte is captured in that same cycle.
module rtc_intflag #(
    parameter int NTAPS = 15,
    parameter int SEL_W = $clog2(NTAPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTAPS-1:0] div_taps,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             alarm_evt,
    input  logic             update_evt,
    input  logic             pie,
    input  logic             aie,
    input  logic             uie,
    input  logic             rd_stb,
    output logic [7:0]       flag_byte,
    output logic             irq
);
    import rtcf_pkg::*;

    rtcf_src_t set_v;
    rtcf_src_t flag_v;
    rtcf_src_t en_v;
    logic      per_rise;
    logic      summary;

    rtcf_tap_edge #(.NTAPS(NTAPS), .SEL_W(SEL_W)) u_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (div_taps),
        .sel   (rate_sel),
        .rise  (per_rise)
    );

    // Gather set requests and enables in source order
    always_comb begin
        set_v = '{per: per_rise, alm: alarm_evt, upd: update_evt};
        en_v  = '{per: pie, alm: aie, upd: uie};
    end

    genvar gs;
    generate
        for (gs = 0; gs < NUM_SRC; gs++) begin : g_flag
            rtcf_flag_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_v[gs]),
                .clr_i (rd_stb),
                .q     (flag_v[gs])
            );
        end
    endgenerate

    rtcf_irq_merge #(.N(NUM_SRC)) u_merge (
        .flags   (flag_v),
        .enables (en_v),
        .req     (summary)
    );

    // Assemble the read-only byte; low nibble is fixed at zero
    always_comb begin
        flag_byte          = 8'h00;
        flag_byte[BIT_IRQ] = summary;
        flag_byte[BIT_PER] = flag_v.per;
        flag_byte[BIT_ALM] = flag_v.alm;
        flag_byte[BIT_UPD] = flag_v.upd;
    end

    // Interrupt is a level taken from the summary flag
    always_comb irq = summary;
endmodule

// File: rtl/rtc_intflag_chk.sv
// Assertion checker for rtc_intflag, attached through bind. Observes ports only.
module rtc_intflag_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       alarm_evt,
    input logic       update_evt,
    input logic       rd_stb,
    input logic [7:0] flag_byte,
    input logic       irq
);
    // R2: alarm pulse sets the alarm flag
    p_alarm_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> flag_byte[5]);

    // R3: update pulse sets the update flag
    p_update_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        update_evt |=> flag_byte[4]);

    // R6: low nibble is always zero
    p_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_byte[3:0] == 4'h0);

    // R7: interrupt level matches the summary bit
    p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == flag_byte[7]);

    // R8: a read with no alarm event clears the alarm flag
    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !alarm_evt) |=> !flag_byte[5]);

    // R9: alarm coinciding with a read survives it
    p_keep_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && alarm_evt) |=> flag_byte[5]);

    // R10: without reads or events the alarm and update flags hold
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !alarm_evt && !update_evt) |=> $stable(flag_byte[5:4]));
endmodule

bind rtc_intflag rtc_intflag_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alarm_evt  (alarm_evt),
    .update_evt (update_evt),
    .rd_stb     (rd_stb),
    .flag_byte  (flag_byte),
    .irq        (irq)
);

// File: tb/rtc_intflag_test.sv
// Bench for rtc_intflag: behavioural reference model compared after every clock.
module rtc_intflag_test;
    localparam int CLK_PERIOD = 10;
    localparam int NTAPS = 15;
    localparam int SEL_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NTAPS-1:0] div_taps;
    logic [SEL_W-1:0] rate_sel;
    logic             alarm_evt, update_evt, pie, aie, uie, rd_stb;
    logic [7:0]       flag_byte;
    logic             irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Model state
    bit               m_per, m_alm, m_upd;
    logic [NTAPS-1:0] m_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_intflag #(.NTAPS(NTAPS), .SEL_W(SEL_W)) uut (
        .clk(clk), .rst_n(rst_n), .div_taps(div_taps), .rate_sel(rate_sel),
        .alarm_evt(alarm_evt), .update_evt(update_evt),
        .pie(pie), .aie(aie), .uie(uie), .rd_stb(rd_stb),
        .flag_byte(flag_byte), .irq(irq)
    );

    function automatic logic [7:0] expected_byte();
        bit sum;
        sum = (m_per && pie) || (m_alm && aie) || (m_upd && uie);
        return {sum, m_per, m_alm, m_upd, 4'b0000};
    endfunction

    // Advance the model with the held inputs, clock once, compare
    task automatic step(input string tag);
        bit edge_seen;
        logic [7:0] exp;
        edge_seen = 0;
        if (!rst_n) begin
            m_per = 0; m_alm = 0; m_upd = 0; m_last = '0;
        end else begin
            if (rate_sel >= 1 && int'(rate_sel) <= NTAPS)
                edge_seen = div_taps[rate_sel-1] && !m_last[rate_sel-1];
            m_per  = edge_seen || (m_per && !rd_stb);
            m_alm  = alarm_evt || (m_alm && !rd_stb);
            m_upd  = update_evt || (m_upd && !rd_stb);
            m_last = div_taps;
        end
        @(posedge clk);
        #1;
        exp = expected_byte();
        vectors++;
        if (flag_byte !== exp || irq !== exp[7]) begin
            errors++;
            $display("FAIL %s: flag_byte=%02h irq=%b expected flag_byte=%02h irq=%b",
                     tag, flag_byte, irq, exp, exp[7]);
        end
        #2;
        alarm_evt = 0; update_evt = 0; rd_stb = 0;
    endtask

    // Targeted check of one byte value after a step
    task automatic expect_byte(input string tag, input logic [7:0] want);
        vectors++;
        if (flag_byte !== want) begin
            errors++;
            $display("FAIL %s: flag_byte=%02h expected %02h", tag, flag_byte, want);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; div_taps = '0; rate_sel = '0;
        alarm_evt = 0; update_evt = 0; pie = 0; aie = 0; uie = 0; rd_stb = 0;
        m_last = '0;
        #2;
        // R1: reset state
        repeat (3) step("R1 reset");
        rst_n = 1;
        step("R1 after reset");
        expect_byte("R1", 8'h00);

        // R2: alarm sets bit 5 and sticks
        alarm_evt = 1; step("R2 alarm");
        expect_byte("R2", 8'h20);
        step("R2 hold");
        expect_byte("R2 sticky", 8'h20);
        aie = 1; step("R6 alarm enable");
        expect_byte("R6 summary", 8'hA0);
        // R8: read clears
        rd_stb = 1; step("R8 read");
        expect_byte("R8", 8'h00);

        // R3: update sets bit 4
        update_evt = 1; step("R3 update");
        expect_byte("R3", 8'h10);
        uie = 1; step("R7 irq level");
        expect_byte("R7", 8'h90);
        // R10: enables change only bit 7
        uie = 0; aie = 0; pie = 1; step("R10 enables");
        expect_byte("R10", 8'h10);
        rd_stb = 1; step("R8 read2");

        // R4: periodic on tap 2 via select 3
        rate_sel = 3; div_taps = 15'b000_0000_0000_0100; step("R4 rise");
        expect_byte("R4 set", 8'hC0);
        rd_stb = 1; step("R4 read");
        step("R4 level held");
        expect_byte("R4 no retrigger", 8'h00);
        div_taps = '0; step("R4 fall");
        // R4: top tap through select NTAPS
        rate_sel = SEL_W'(NTAPS); div_taps = 15'h4000; step("R4 top tap");
        expect_byte("R4 top", 8'hC0);
        rd_stb = 1; div_taps = '0; step("R4 clear");

        // R5: select 0 never sets
        rate_sel = 0;
        for (int i = 0; i < 6; i++) begin
            div_taps = (i % 2) ? '1 : '0; step("R5 no tap");
        end
        expect_byte("R5", 8'h00);

        // R9: events coinciding with a read stay set
        alarm_evt = 1; step("R9 prep");
        rd_stb = 1; update_evt = 1; step("R9 upd on read");
        expect_byte("R9 upd", 8'h10);
        rate_sel = 1; div_taps = '0; step("R9 tap low");
        rd_stb = 1; div_taps = 15'h0001; step("R9 per on read");
        expect_byte("R9 per", 8'hC0);
        rd_stb = 1; alarm_evt = 1; step("R9 alm on read");
        expect_byte("R9 alm", 8'h20);

        // Random phase across all requirements
        for (int k = 0; k < 3000; k++) begin
            div_taps   = NTAPS'($urandom);
            rate_sel   = SEL_W'($urandom);
            alarm_evt  = ($urandom % 8) == 0;
            update_evt = ($urandom % 8) == 0;
            rd_stb     = ($urandom % 5) == 0;
            pie = $urandom; aie = $urandom; uie = $urandom;
            if (($urandom % 200) == 0) rst_n = 0;
            step("R2 R3 R4 R6 R7 R8 R9 random");
            rst_n = 1;
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule